// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

This block holds two 8-bit up-counters, each compared against its own 8-bit limit register. The counters run on single-cycle count enables in the system clock domain. Counter 0 takes its enable from a synchronised external clock pin or from one of three prescaler taps. Counter 1 takes its enable from a second set of taps, or from counter 0's compare event. The pair can also be chained, so that counter 1 counts the wraps of counter 0 and the two act as one 16-bit interval timer.

There are four operating modes: two independent timers, the chained 16-bit timer, a PWM period mode with a selectable wrap length, and a programmable-pulse mode. In the programmable-pulse mode counter 0 is timed by two limits, one for the pulse edge and one for the cycle length. Limit register 0 can be double-buffered. When buffering is on, software writes land in a shadow copy, and the shadow reaches the live register only at a period boundary. Software programs the block through a small synchronous register write port. The match and wrap pulses feed output-pin and interrupt logic that lies outside this block.

Top module: `tmr_pair8`

## Requirements
- R1: After reset both counters read 0, limit register 0 reads 0, both counters are stopped, and no match or wrap pulse is asserted.
- R2: Counter 0 advances only on the tick chosen by control bits [3:2]: 0 = rising edge of the external pin after a two-flop synchroniser, 1 = divide-by-1 tap, 2 = divide-by-4 tap, 3 = divide-by-16 tap. Ticks from the taps that are not selected are ignored.
- R3: In independent mode (control bits [1:0] = 0), a counter whose limit is non-zero counts up to that limit, raises a one-cycle match pulse while it holds the limit, and restarts from 0 on the next tick, giving a period of limit+1 ticks.
- R4: A limit of 0 means the match pulse fires when the counter wraps from FFh to 0. Every such wrap also raises the wrap pulse, and the counter reads 0 in that cycle.
- R5: A counter whose run bit is clear (write address 1: bit 0 for counter 0, bit 1 for counter 1) holds its value whatever ticks arrive.
- R6: Outside chained mode, counter 1 advances on the tick chosen by control bits [5:4]: 0 = divide-by-1, 1 = divide-by-16, 2 = divide-by-256, 3 = counter 0's match event.
- R7: In chained mode (mode 1), counter 1 advances on each wrap of counter 0. Counter 0 raises no match pulse. Counter 1's match pulse fires when the 16-bit value {counter 1, counter 0} reaches {limit 1, limit 0}, and both counters then restart from 0 on the next counter 0 tick.
- R8: In PWM mode (mode 2), counter 0 wraps at 2^n-1, where n = 6, 7 or 8 for control bits [7:6] = 0, 1 or 2 (3 also gives 8). It raises its match pulse when it reaches limit 0, or at the wrap when limit 0 is 0.
- R9: With buffering off (write address 1, bit 2 clear), a write to address 2 takes effect in limit register 0 on the next cycle.
- R10: With buffering on in PWM mode, a write to address 2 leaves limit register 0 unchanged until counter 0 next wraps, and the written value is loaded at that wrap.
- R11: In programmable-pulse mode (mode 3), counter 0 restarts after reaching limit 1 and counter 1 is idle. The match 0 pulse marks limit 0 and the match 1 pulse marks limit 1. With buffering on, the shadow value is loaded into limit register 0 at the limit-1 match.
- R12: In independent mode the buffer enable has no effect, and writes to address 2 reach limit register 0 directly.
- R13: Match and wrap outputs are single-cycle pulses, and a match pulse coincides with the counter holding the limit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 run/buffer, 2 limit 0, 3 limit 1 |
| wr_data | input | 8 | Write data |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| tap1_i | input | 1 | Divide-by-1 prescaler enable |
| tap4_i | input | 1 | Divide-by-4 prescaler enable |
| tap16_i | input | 1 | Divide-by-16 prescaler enable |
| tap256_i | input | 1 | Divide-by-256 prescaler enable |
| cnt0_o | output | 8 | Counter 0 value |
| cnt1_o | output | 8 | Counter 1 value |
| cmp0_o | output | 8 | Live value of limit register 0 |
| match0_o | output | 1 | Counter 0 match pulse |
| match1_o | output | 1 | Counter 1 (or 16-bit / cycle) match pulse |
| ovf0_o | output | 1 | Counter 0 wrap pulse |
| ovf1_o | output | 1 | Counter 1 wrap pulse |

## Verification
Some properties are checked on every cycle. Each wrap pulse must leave its counter at 0. A match pulse must land while counter 0 holds an unchanged limit. A stopped counter must not move. Chained mode must keep match 0 silent. Period lengths, the cascade carry, the tap selection and the external-pin edge count can only be shown by the bench's scenarios, because they depend on the tick streams driven into the block. The same holds for when the shadow register reaches the live limit, and for the buffer enable being ignored in independent mode.

// File: rtl/tmr_pair8_pkg.sv
package tmr_pair8_pkg;

    localparam int CNT_W  = 8;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        MODE_DUAL  = 2'd0,
        MODE_CHAIN = 2'd1,
        MODE_PWM   = 2'd2,
        MODE_PPG   = 2'd3
    } tmode_e;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_RUN  = 2'd1,
        ADDR_LIM0 = 2'd2,
        ADDR_LIM1 = 2'd3
    } addr_e;

    // control byte: [7:6] pwm width, [5:4] counter 1 source, [3:2] counter 0 source, [1:0] mode
    typedef struct packed {
        logic [1:0] pwm_w;
        logic [1:0] src1;
        logic [1:0] src0;
        tmode_e     mode;
    } ctrl_t;

    // run byte low bits: [2] buffer enable, [1] run counter 1, [0] run counter 0
    typedef struct packed {
        logic buf_en;
        logic run1;
        logic run0;
    } run_t;

    localparam int RUN_W = $bits(run_t);

    // wrap value of counter 0 in PWM mode: 2^n - 1 with n = CNT_W-2, CNT_W-1, CNT_W
    function automatic cnt_t pwm_top(input logic [1:0] w);
        cnt_t t;
        case (w)
            2'd0:    t = cnt_t'((1 << (CNT_W - 2)) - 1);
            2'd1:    t = cnt_t'((1 << (CNT_W - 1)) - 1);
            default: t = '1;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tmr_pair8_tick.sv
module tmr_pair8_tick
    import tmr_pair8_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_i,
    input  logic       tap1_i,
    input  logic       tap4_i,
    input  logic       tap16_i,
    input  logic       tap256_i,
    input  logic [1:0] src0,
    input  logic [1:0] src1,
    input  logic       m0_ev,
    output logic       tick0,
    output logic       tick1_sel
);

    // SYNC_N synchroniser stages plus one history flop for edge detection
    logic [SYNC_N:0] sh_q;
    logic            ext_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_N-1:0], ext_i};
        end
    end

    assign ext_rise = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];

    always_comb begin
        case (src0)
            2'd0:    tick0 = ext_rise;
            2'd1:    tick0 = tap1_i;
            2'd2:    tick0 = tap4_i;
            default: tick0 = tap16_i;
        endcase
    end

    always_comb begin
        case (src1)
            2'd0:    tick1_sel = tap1_i;
            2'd1:    tick1_sel = tap16_i;
            2'd2:    tick1_sel = tap256_i;
            default: tick1_sel = m0_ev;
        endcase
    end

endmodule

// File: rtl/tmr_pair8_count.sv
module tmr_pair8_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         restart,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic [W-1:0] after,
    output logic         wrap
);

    logic [W-1:0] nxt;

    assign nxt   = (restart || cnt == top) ? '0 : cnt + 1'b1;
    assign after = adv ? nxt : cnt;
    assign wrap  = adv && (cnt == top);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= nxt;
        end
    end

endmodule

// File: rtl/tmr_pair8_regs.sv
module tmr_pair8_regs
    import tmr_pair8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              reload,
    output ctrl_t             ctrl,
    output run_t              run,
    output cnt_t              lim0,
    output cnt_t              lim1
);

    cnt_t  shadow_q;
    logic  buffered;
    addr_e addr;

    assign addr     = addr_e'(wr_addr);
    assign buffered = run.buf_en && (ctrl.mode == MODE_PWM || ctrl.mode == MODE_PPG);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            run      <= '0;
            lim0     <= '0;
            lim1     <= '0;
            shadow_q <= '0;
        end else begin
            if (reload && buffered) begin
                lim0 <= shadow_q;
            end
            if (wr_en) begin
                case (addr)
                    ADDR_CTRL: ctrl <= ctrl_t'(wr_data);
                    ADDR_RUN:  run  <= run_t'(wr_data[RUN_W-1:0]);
                    ADDR_LIM0: begin
                        shadow_q <= cnt_t'(wr_data);
                        if (!buffered) begin
                            lim0 <= cnt_t'(wr_data);
                        end
                    end
                    default:   lim1 <= cnt_t'(wr_data);
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_pair8.sv
module tmr_pair8
    import tmr_pair8_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ext_clk_i,
    input  logic              tap1_i,
    input  logic              tap4_i,
    input  logic              tap16_i,
    input  logic              tap256_i,
    output logic [CNT_W-1:0]  cnt0_o,
    output logic [CNT_W-1:0]  cnt1_o,
    output logic [CNT_W-1:0]  cmp0_o,
    output logic              match0_o,
    output logic              match1_o,
    output logic              ovf0_o,
    output logic              ovf1_o
);

    localparam int NCNT = 2;

    ctrl_t  ctrl;
    run_t   run;
    cnt_t   lim0, lim1;
    tmode_e mode_w;
    logic   run0_w;

    logic   tick0, tick1_sel, tick1;
    logic   ev_m0, ev_m1, reload;
    logic   restart16;

    logic [NCNT-1:0] adv, restart, wrap;
    cnt_t            top   [NCNT];
    cnt_t            cnt   [NCNT];
    cnt_t            after [NCNT];

    logic [2*CNT_W-1:0] cnt16, lim16, after16;

    logic is_chain, is_pwm, is_ppg;

    assign mode_w   = ctrl.mode;
    assign run0_w   = run.run0;
    assign is_chain = (ctrl.mode == MODE_CHAIN);
    assign is_pwm   = (ctrl.mode == MODE_PWM);
    assign is_ppg   = (ctrl.mode == MODE_PPG);

    tmr_pair8_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .reload  (reload),
        .ctrl    (ctrl),
        .run     (run),
        .lim0    (lim0),
        .lim1    (lim1)
    );

    tmr_pair8_tick #(.SYNC_N(SYNC_N)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .ext_i     (ext_clk_i),
        .tap1_i    (tap1_i),
        .tap4_i    (tap4_i),
        .tap16_i   (tap16_i),
        .tap256_i  (tap256_i),
        .src0      (ctrl.src0),
        .src1      (ctrl.src1),
        .m0_ev     (ev_m0),
        .tick0     (tick0),
        .tick1_sel (tick1_sel)
    );

    assign cnt16   = {cnt[1], cnt[0]};
    assign lim16   = {lim1, lim0};
    assign after16 = {after[1], after[0]};

    // joint restart of the 16-bit chain once it holds a non-zero limit
    assign restart16 = is_chain && (lim16 != '0) && (cnt16 == lim16);

    // counter 0 controls
    assign adv[0] = tick0 && run.run0;
    assign top[0] = is_pwm ? pwm_top(ctrl.pwm_w) : '1;

    always_comb begin
        case (ctrl.mode)
            MODE_DUAL:  restart[0] = (lim0 != '0) && (cnt[0] == lim0);
            MODE_CHAIN: restart[0] = restart16;
            MODE_PPG:   restart[0] = (lim1 != '0) && (cnt[0] == lim1);
            default:    restart[0] = 1'b0;
        endcase
    end

    // counter 1 controls
    always_comb begin
        if (is_chain) begin
            tick1 = adv[0] && (wrap[0] || restart16);
        end else if (is_ppg) begin
            tick1 = 1'b0;
        end else begin
            tick1 = tick1_sel;
        end
    end

    assign adv[1]     = tick1 && run.run1;
    assign top[1]     = '1;
    assign restart[1] = is_chain ? restart16 : ((lim1 != '0) && (cnt[1] == lim1));

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_cnt
            tmr_pair8_count #(.W(CNT_W)) u_count (
                .clk     (clk),
                .rst     (rst),
                .adv     (adv[g]),
                .restart (restart[g]),
                .top     (top[g]),
                .cnt     (cnt[g]),
                .after   (after[g]),
                .wrap    (wrap[g])
            );
        end
    endgenerate

    // match events
    assign ev_m0 = !is_chain && adv[0] && (after[0] == lim0);

    always_comb begin
        case (ctrl.mode)
            MODE_CHAIN: ev_m1 = adv[0] && (after16 == lim16);
            MODE_PPG:   ev_m1 = adv[0] && (after[0] == lim1);
            default:    ev_m1 = adv[1] && (after[1] == lim1);
        endcase
    end

    // shadow transfer points: PWM wrap or cycle match
    assign reload = (is_pwm && wrap[0]) || (is_ppg && ev_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            match0_o <= 1'b0;
            match1_o <= 1'b0;
            ovf0_o   <= 1'b0;
            ovf1_o   <= 1'b0;
        end else begin
            match0_o <= ev_m0;
            match1_o <= ev_m1;
            ovf0_o   <= wrap[0];
            ovf1_o   <= wrap[1];
        end
    end

    assign cnt0_o = cnt[0];
    assign cnt1_o = cnt[1];
    assign cmp0_o = lim0;

endmodule

// File: rtl/tmr_pair8_chk.sv
module tmr_pair8_chk
    import tmr_pair8_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input tmode_e     mode,
    input logic       run0,
    input logic [7:0] cnt0_o,
    input logic [7:0] cnt1_o,
    input logic [7:0] cmp0_o,
    input logic       match0_o,
    input logic       ovf0_o,
    input logic       ovf1_o
);

    // R4: a wrap of counter 0 leaves it at zero
    p_wrap0_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ovf0_o |-> cnt0_o == '0);

    // R4: a wrap of counter 1 leaves it at zero
    p_wrap1_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ovf1_o |-> cnt1_o == '0);

    // R13: a match pulse coincides with counter 0 holding an unchanged limit
    p_match_at_limit_r13: assert property (@(posedge clk) disable iff (rst)
        (match0_o && $stable(cmp0_o)) |-> cnt0_o == cmp0_o);

    // R5: a stopped counter holds its value
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run0)) |-> $stable(cnt0_o));

    // R7: chained mode keeps match 0 quiet
    p_chain_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == MODE_CHAIN) |-> !match0_o);

endmodule

bind tmr_pair8 tmr_pair8_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_w),
    .run0     (run0_w),
    .cnt0_o   (cnt0_o),
    .cnt1_o   (cnt1_o),
    .cmp0_o   (cmp0_o),
    .match0_o (match0_o),
    .ovf0_o   (ovf0_o),
    .ovf1_o   (ovf1_o)
);

// File: tb/tmr_pair8_test.sv
`timescale 1ns/1ps
module tmr_pair8_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_clk_i = 1'b0;
    logic       tap1_i = 1'b1;
    logic       tap4_i = 1'b0;
    logic       tap16_i = 1'b0;
    logic       tap256_i = 1'b0;
    logic [7:0] cnt0_o, cnt1_o, cmp0_o;
    logic       match0_o, match1_o, ovf0_o, ovf1_o;

    int checks = 0;
    int errors = 0;
    int m0_seen = 0, m1_seen = 0, ovf0_seen = 0, run_len = 0, max_run = 0;
    logic [7:0] run_extra = 8'h00;

    always #4 clk = ~clk;

    tmr_pair8 uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ext_clk_i (ext_clk_i),
        .tap1_i    (tap1_i),
        .tap4_i    (tap4_i),
        .tap16_i   (tap16_i),
        .tap256_i  (tap256_i),
        .cnt0_o    (cnt0_o),
        .cnt1_o    (cnt1_o),
        .cmp0_o    (cmp0_o),
        .match0_o  (match0_o),
        .match1_o  (match1_o),
        .ovf0_o    (ovf0_o),
        .ovf1_o    (ovf1_o)
    );

    always @(negedge clk) begin
        if (match0_o) begin
            m0_seen++;
            run_len++;
        end else begin
            run_len = 0;
        end
        if (run_len > max_run) max_run = run_len;
        if (match1_o) m1_seen++;
        if (ovf0_o) ovf0_seen++;
    end

    // vector: control, limit 0, limit 1, ticks, expected cnt0, cnt1, match0 count, match1 count
    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  c0;
        logic [7:0]  c1;
        logic [15:0] n;
        logic [7:0]  e0;
        logic [7:0]  e1;
        logic [7:0]  m0;
        logic [7:0]  m1;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h34, 8'd9, 8'd0, 16'd25,  8'd5,  8'd2,   8'd2, 8'd0},
        '{8'h04, 8'd0, 8'd0, 16'd300, 8'd44, 8'd44,  8'd1, 8'd1},
        '{8'h34, 8'd1, 8'd3, 16'd7,   8'd1,  8'd0,   8'd4, 8'd1},
        '{8'h05, 8'd0, 8'd0, 16'd600, 8'd88, 8'd2,   8'd0, 8'd0},
        '{8'h05, 8'd5, 8'd1, 16'd600, 8'd76, 8'd0,   8'd0, 8'd2},
        '{8'h06, 8'd10, 8'd0, 16'd130, 8'd2, 8'd130, 8'd2, 8'd0},
        '{8'h46, 8'd0, 8'd0, 16'd300, 8'd44, 8'd44,  8'd2, 8'd1},
        '{8'h07, 8'd3, 8'd7, 16'd20,  8'd4,  8'd0,   8'd3, 8'd2},
        '{8'h86, 8'd0, 8'd0, 16'd300, 8'd44, 8'd44,  8'd1, 8'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // caller stands at a negedge; returns at the negedge after the capture edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run_extra = 8'h00;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // exactly n ticks of a one-per-cycle source reach the counters
    task automatic run_ticks(input int n);
        wr(2'd1, run_extra | 8'h03);
        repeat (n - 1) @(negedge clk);
        wr(2'd1, run_extra);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 cnt0", cnt0_o, 0);
        check("R1 cnt1", cnt1_o, 0);
        check("R1 cmp0", cmp0_o, 0);
        check("R1 pulses", {match0_o, match1_o, ovf0_o, ovf1_o}, 0);

        // table of mode scenarios with the divide-by-1 tap feeding the counters
        for (int i = 0; i < NV; i++) begin
            string tag;
            case (VECS[i].ctrl[1:0])
                2'd0:    tag = "R3";
                2'd1:    tag = "R7";
                2'd2:    tag = "R8";
                default: tag = "R11";
            endcase
            do_reset();
            wr(2'd0, VECS[i].ctrl);
            wr(2'd2, VECS[i].c0);
            wr(2'd3, VECS[i].c1);
            m0_seen = 0; m1_seen = 0;
            run_ticks(int'(VECS[i].n));
            repeat (3) @(negedge clk);
            check($sformatf("%s v%0d cnt0", tag, i), cnt0_o, int'(VECS[i].e0));
            check($sformatf("%s v%0d cnt1", tag, i), cnt1_o, int'(VECS[i].e1));
            check($sformatf("%s v%0d match0", tag, i), m0_seen, int'(VECS[i].m0));
            check($sformatf("%s v%0d match1", tag, i), m1_seen, int'(VECS[i].m1));
        end
        // R13: no match pulse lasted more than one cycle
        check("R13 pulse width", max_run, 1);

        // R4: zero limit wraps at FFh with one wrap pulse
        do_reset();
        wr(2'd0, 8'h04);
        ovf0_seen = 0; m0_seen = 0;
        run_ticks(256);
        repeat (2) @(negedge clk);
        check("R4 cnt0 after 256", cnt0_o, 0);
        check("R4 wrap pulses", ovf0_seen, 1);
        check("R4 match at wrap", m0_seen, 1);

        // R2: external pin edges counted, divide-by-1 tap ignored
        do_reset();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h03);
        for (int k = 0; k < 5; k++) begin
            ext_clk_i = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R2 ext pin edges", cnt0_o, 5);

        // R2: divide-by-4 source ignores divide-by-1 ticks
        do_reset();
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h03);
        repeat (10) @(negedge clk);
        check("R2 tap4 ignores tap1", cnt0_o, 0);
        for (int k = 0; k < 2; k++) begin
            tap4_i = 1'b1; @(negedge clk);
            tap4_i = 1'b0; @(negedge clk);
        end
        check("R2 tap4 counts", cnt0_o, 2);

        // R5: stopped counter ignores ticks
        wr(2'd1, 8'h00);
        for (int k = 0; k < 3; k++) begin
            tap4_i = 1'b1; @(negedge clk);
            tap4_i = 1'b0; @(negedge clk);
        end
        check("R5 stopped hold", cnt0_o, 2);

        // R6: counter 1 on the divide-by-256 tap
        do_reset();
        wr(2'd0, 8'h24);
        wr(2'd1, 8'h03);
        for (int k = 0; k < 3; k++) begin
            tap256_i = 1'b1; @(negedge clk);
            tap256_i = 1'b0; repeat (2) @(negedge clk);
        end
        check("R6 tap256 count", cnt1_o, 3);

        // R9: unbuffered write is immediate
        do_reset();
        wr(2'd2, 8'h40);
        check("R9 direct write", cmp0_o, 8'h40);

        // R12: buffer enable ignored in independent mode
        do_reset();
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h04);
        wr(2'd2, 8'h11);
        check("R12 buffer ignored", cmp0_o, 8'h11);

        // R10: PWM shadow loaded at the 2^6-1 wrap
        do_reset();
        wr(2'd0, 8'h06);
        wr(2'd2, 8'd20);
        wr(2'd1, 8'h04);
        run_extra = 8'h04;
        wr(2'd2, 8'd30);
        check("R10 held before wrap", cmp0_o, 20);
        run_ticks(63);
        check("R10 cnt0 at top", cnt0_o, 63);
        check("R10 still held at top", cmp0_o, 20);
        run_ticks(1);
        check("R10 loaded at wrap", cmp0_o, 30);
        check("R10 cnt0 wrapped", cnt0_o, 0);

        // R11: cycle-match reload in programmable-pulse mode
        do_reset();
        wr(2'd0, 8'h07);
        wr(2'd3, 8'd5);
        wr(2'd2, 8'd2);
        wr(2'd1, 8'h04);
        run_extra = 8'h04;
        wr(2'd2, 8'd4);
        run_ticks(4);
        check("R11 held mid-cycle", cmp0_o, 2);
        run_ticks(1);
        check("R11 loaded at cycle match", cmp0_o, 4);
        check("R11 cnt0 at cycle limit", cnt0_o, 5);
        run_ticks(1);
        check("R11 restart after limit", cnt0_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule